// File: doc/BRIEF.md
# Dual-Lane SPI Flash Image Loader

This block copies a boot image from a serial flash into a word-wide memory once a start pulse arrives. It lowers chip select and sends the dual-output fast-read opcode and a 24-bit flash address on a single data line. After eight dummy clocks it releases that line and receives two bits per serial clock, one on each data line. The first 32-bit word it receives is a byte count. The block rounds that count up to whole words and reads that many words in one unbroken burst.

Each received word arrives most significant byte first. The block reverses its byte order and writes it to the memory port at consecutive word addresses, starting at 0. After the final write it raises chip select, stops the serial clock and holds a completion flag. The serial clock period is a parameter, and the flash start address is an input sampled at start.

Top module: `dual_spi_image_loader`

## Requirements
- R1: A start pulse while the block is idle or finished lowers `spi_cs_n`. The block then sends 32 bits on `spi_io0_out`, most significant bit first: the opcode 0x3B, then `flash_base[23:0]`. Each bit changes only on a falling SCLK edge and is stable at the following rising edge.
- R2: `spi_sclk` is low whenever `spi_cs_n` is high. While the block is selected, `spi_sclk` has a period of SCLK_DIV system clocks: SCLK_DIV/2 low, then SCLK_DIV/2 high.
- R3: Eight dummy SCLK cycles follow the address. `spi_io0_oe` is high from the start pulse until the falling edge that ends the eighth dummy clock, and low after it. It is also low whenever `spi_cs_n` is high.
- R4: In the data phase, each rising SCLK edge samples one pair of bits. `spi_io1_in` is the higher, odd-numbered bit and `spi_io0_in` is the lower, even-numbered bit. The first pair is bits 31 and 30. Sixteen SCLK cycles make one 32-bit word.
- R5: The first data word is the image length in bytes, with its most significant byte first in flash. The block then reads ceil(length/4) image words with no gap between them.
- R6: Each image word is written with a one-cycle `mem_we` pulse, at word addresses 0, 1, 2 and so on. The byte received first goes to `mem_wdata[7:0]`, and the byte received last goes to `mem_wdata[31:24]`.
- R7: `spi_cs_n` rises in the same cycle as the last write. SCLK then stays low, and `done` goes high and stays high until the next accepted start.
- R8: A length of 0 raises `spi_cs_n` and sets `done` right after the header word, with no memory write.
- R9: A start pulse during a transfer has no effect. The command, the address and the written data are those of the transfer already running.
- R10: After reset, `spi_cs_n`=1, `spi_sclk`=0, `spi_io0_oe`=0, `mem_we`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (one-cycle pulse) |
| flash_base | input | 24 | Flash byte address of the length header |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_io0_out | output | 1 | Data line 0 output value |
| spi_io0_oe | output | 1 | Data line 0 output enable |
| spi_io0_in | input | 1 | Data line 0 input (even bits) |
| spi_io1_in | input | 1 | Data line 1 input (odd bits) |
| mem_addr | output | MEM_AW | Word address of the memory write |
| mem_wdata | output | 32 | Little-endian image word |
| mem_we | output | 1 | Memory write strobe |
| done | output | 1 | Load finished |

## Verification
A wrong bit count in the command phase is visible at once: the opcode and address the flash model receives are garbled. If the block releases the data line a dummy clock early or late, the model either sees the line still driven in the same SCLK cycle as its first data bit, or receives a wrong first pair. A fault in the pair order or the byte swap corrupts every word as soon as it is written. A fault in the length rounding or the word counter changes the number of writes, or the moment chip select rises, in the last word of the burst.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DUMMY,
        ST_HDR,
        ST_BODY,
        ST_DONE
    } dsl_state_e;

    localparam logic [7:0] DSL_OP_DUAL_READ = 8'h3B;
    localparam int DSL_OP_BITS    = 8;
    localparam int DSL_ADDR_BITS  = 24;
    localparam int DSL_DUMMY_CLKS = 8;
    localparam int DSL_WORD_BITS  = 32;
    localparam int DSL_LANES      = 2;
    localparam int DSL_HEAD_BITS  = DSL_OP_BITS + DSL_ADDR_BITS;
    localparam int DSL_WORD_CLKS  = DSL_WORD_BITS / DSL_LANES;

    typedef struct packed {
        logic odd;
        logic even;
    } dsl_pair_t;

    function automatic logic [DSL_WORD_BITS-1:0] dsl_bswap(input logic [DSL_WORD_BITS-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [30:0] dsl_len_to_words(input logic [31:0] len);
        return {1'b0, len[31:2]} + {30'd0, |len[1:0]};
    endfunction

endpackage

// File: rtl/dsl_sclk_div.sv
module dsl_sclk_div #(
    parameter int SCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int HALF = SCLK_DIV / 2;
    localparam int CW   = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;

    logic [CW-1:0] cnt;

    assign rise_evt = run && (cnt == CW'(HALF - 1));
    assign fall_evt = run && (cnt == CW'(SCLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else begin
            cnt <= (cnt == CW'(SCLK_DIV - 1)) ? '0 : cnt + 1'b1;
            if (rise_evt)
                sclk <= 1'b1;
            else if (fall_evt)
                sclk <= 1'b0;
        end
    end
endmodule

// File: rtl/dsl_pair_shift.sv
module dsl_pair_shift
    import dsl_pkg::*;
#(
    parameter int W = DSL_WORD_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         sample,
    input  dsl_pair_t    pair,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            word <= '0;
        else if (sample)
            word <= {word[W-3:0], pair.odd, pair.even};
    end
endmodule

// File: rtl/dual_spi_image_loader.sv
module dual_spi_image_loader
    import dsl_pkg::*;
#(
    parameter int SCLK_DIV = 4,
    parameter int MEM_AW   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [23:0]       flash_base,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_io0_out,
    output logic              spi_io0_oe,
    input  logic              spi_io0_in,
    input  logic              spi_io1_in,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              mem_we,
    output logic              done
);
    localparam int BCW = $clog2(DSL_HEAD_BITS);

    dsl_state_e              state;
    logic [DSL_HEAD_BITS-1:0] out_sh;
    logic [BCW-1:0]          bit_cnt;
    logic [30:0]             words;
    logic [30:0]             word_idx;
    logic                    run, rise_evt, fall_evt;
    logic                    accept;
    logic [DSL_WORD_BITS-1:0] in_word;
    dsl_pair_t               pair;

    assign run    = (state != ST_IDLE) && (state != ST_DONE);
    assign accept = start && !run;
    assign pair   = '{odd: spi_io1_in, even: spi_io0_in};
    assign spi_io0_out = out_sh[DSL_HEAD_BITS-1];

    dsl_sclk_div #(.SCLK_DIV(SCLK_DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sclk     (spi_sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    dsl_pair_shift #(.W(DSL_WORD_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .sample (rise_evt && (state == ST_HDR || state == ST_BODY)),
        .pair   (pair),
        .word   (in_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            spi_cs_n   <= 1'b1;
            spi_io0_oe <= 1'b0;
            out_sh     <= '0;
            bit_cnt    <= '0;
            words      <= '0;
            word_idx   <= '0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            mem_we     <= 1'b0;
            done       <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        state      <= ST_CMD;
                        spi_cs_n   <= 1'b0;
                        spi_io0_oe <= 1'b1;
                        out_sh     <= {DSL_OP_DUAL_READ, flash_base};
                        bit_cnt    <= '0;
                        word_idx   <= '0;
                        done       <= 1'b0;
                    end
                end
                ST_CMD: begin
                    if (fall_evt) begin
                        out_sh <= out_sh << 1;
                        if (bit_cnt == BCW'(DSL_HEAD_BITS - 1)) begin
                            state   <= ST_DUMMY;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_DUMMY: begin
                    if (fall_evt) begin
                        out_sh <= out_sh << 1;
                        if (bit_cnt == BCW'(DSL_DUMMY_CLKS - 1)) begin
                            spi_io0_oe <= 1'b0;
                            state      <= ST_HDR;
                            bit_cnt    <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_HDR: begin
                    if (fall_evt) begin
                        if (bit_cnt == BCW'(DSL_WORD_CLKS - 1)) begin
                            bit_cnt <= '0;
                            words   <= dsl_len_to_words(in_word);
                            if (dsl_len_to_words(in_word) == '0) begin
                                spi_cs_n <= 1'b1;
                                done     <= 1'b1;
                                state    <= ST_DONE;
                            end else begin
                                state <= ST_BODY;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_BODY: begin
                    if (fall_evt) begin
                        if (bit_cnt == BCW'(DSL_WORD_CLKS - 1)) begin
                            bit_cnt   <= '0;
                            mem_we    <= 1'b1;
                            mem_wdata <= dsl_bswap(in_word);
                            mem_addr  <= word_idx[MEM_AW-1:0];
                            word_idx  <= word_idx + 1'b1;
                            if (word_idx == words - 1'b1) begin
                                spi_cs_n <= 1'b1;
                                done     <= 1'b1;
                                state    <= ST_DONE;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsl_loader_checker.sv
module dsl_loader_checker #(
    parameter int MEM_AW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_io0_out,
    input logic              spi_io0_oe,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_we,
    input logic              done
);
    logic              cs_prev;
    logic [MEM_AW-1:0] exp_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev  <= 1'b1;
            exp_addr <= '0;
        end else begin
            cs_prev <= spi_cs_n;
            if (cs_prev && !spi_cs_n)
                exp_addr <= '0;
            else if (mem_we)
                exp_addr <= exp_addr + 1'b1;
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_rise_selected_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> !spi_cs_n);

    p_mosi_stable_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> $stable(spi_io0_out));

    p_oe_released_r3: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_io0_oe);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (spi_cs_n && !spi_sclk));

    p_we_single_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    p_addr_order_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == exp_addr));
endmodule

bind dual_spi_image_loader dsl_loader_checker #(.MEM_AW(MEM_AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_sclk    (spi_sclk),
    .spi_io0_out (spi_io0_out),
    .spi_io0_oe  (spi_io0_oe),
    .mem_addr    (mem_addr),
    .mem_we      (mem_we),
    .done        (done)
);

// File: tb/dual_spi_image_loader_test.sv
module dual_spi_image_loader_test;
    localparam int MEM_AW = 10;
    localparam int NVEC   = 4;
    localparam logic [55:0] VEC [NVEC] = '{
        {24'h010000, 32'd8},
        {24'h010000, 32'd5},
        {24'h0ABCDE, 32'd12},
        {24'h000100, 32'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [23:0] flash_base = 24'h0;
    logic spi_cs_n, spi_sclk, spi_io0_out, spi_io0_oe;
    logic spi_io0_in = 1'b0;
    logic spi_io1_in = 1'b0;
    logic [MEM_AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_we, done;

    dual_spi_image_loader #(.SCLK_DIV(4), .MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst(rst), .start(start), .flash_base(flash_base),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_io0_out(spi_io0_out),
        .spi_io0_oe(spi_io0_oe), .spi_io0_in(spi_io0_in), .spi_io1_in(spi_io1_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cyc);
            report_end();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // flash model
    logic [23:0] cur_base;
    logic [31:0] cur_len;
    logic        sclk_prev = 1'b0;
    int          rcnt = 0;
    int          fcnt = 0;
    logic [31:0] cmd_sh = '0;
    bit          contention = 0;

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        logic [23:0] off;
        off = a - cur_base;
        if (off < 24'd4)
            return 8'(cur_len >> (8 * (3 - int'(off))));
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [31:0] exp_word(input int k);
        logic [23:0] a;
        a = cur_base + 24'd4 + 24'(4 * k);
        return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
    endfunction

    always @(posedge clk) begin
        int p;
        int j;
        logic [7:0] b;
        sclk_prev <= spi_sclk;
        if (spi_cs_n) begin
            rcnt <= 0;
            fcnt <= 0;
        end else begin
            if (spi_sclk && !sclk_prev) begin
                if (rcnt < 32) cmd_sh <= {cmd_sh[30:0], spi_io0_out};
                rcnt <= rcnt + 1;
            end
            if (!spi_sclk && sclk_prev) begin
                fcnt <= fcnt + 1;
                if (fcnt + 1 >= 40) begin
                    p = fcnt + 1 - 40;
                    j = 3 - (p % 4);
                    b = fbyte(cmd_sh[23:0] + 24'(p / 4));
                    spi_io1_in <= b[2*j+1];
                    spi_io0_in <= b[2*j];
                    if (spi_io0_oe) contention = 1;
                end
            end
        end
    end

    // memory capture
    logic [31:0] cap [64];
    int wr_count = 0;
    always @(posedge clk) begin
        if (mem_we) begin
            if (int'(mem_addr) < 64) cap[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic pulse_start(input logic [23:0] base);
        @(negedge clk);
        flash_base = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_load(input string tag);
        int nw;
        nw = int'((cur_len + 32'd3) >> 2);
        chk(cmd_sh == {8'h3B, cur_base}, {tag, " R1 command"}, 64'(cmd_sh), 64'({8'h3B, cur_base}));
        chk(wr_count == nw, {tag, " R5 word count"}, 64'(wr_count), 64'(nw));
        for (int k = 0; k < nw; k++)
            chk(cap[k] == exp_word(k), {tag, " R4 R6 word"}, 64'(cap[k]), 64'(exp_word(k)));
        chk(!contention, {tag, " R3 io0 released before data"}, 64'(contention), 64'd0);
        chk(done && spi_cs_n && !spi_io0_oe && !spi_sclk, {tag, " R7 end state"},
            64'({done, spi_cs_n, spi_io0_oe, spi_sclk}), 64'b1100);
    endtask

    task automatic prep(input logic [23:0] base, input logic [31:0] len);
        cur_base = base;
        cur_len = len;
        contention = 0;
        wr_count = 0;
        for (int k = 0; k < 64; k++) cap[k] = 32'hDEAD_BEEF;
    endtask

    initial begin
        int hi_w;
        int per;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(spi_cs_n == 1'b1, "R10 cs_n", 64'(spi_cs_n), 64'd1);
        chk(spi_sclk == 1'b0, "R10 sclk", 64'(spi_sclk), 64'd0);
        chk(spi_io0_oe == 1'b0, "R10 oe", 64'(spi_io0_oe), 64'd0);
        chk(mem_we == 1'b0, "R10 we", 64'(mem_we), 64'd0);
        chk(done == 1'b0, "R10 done", 64'(done), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            prep(VEC[i][55:32], VEC[i][31:0]);
            pulse_start(cur_base);
            wait_done();
            check_load($sformatf("vec%0d", i));
        end

        // R8 zero length
        prep(24'h123456, 32'd0);
        pulse_start(cur_base);
        wait_done();
        chk(wr_count == 0, "R8 no writes", 64'(wr_count), 64'd0);
        chk(cmd_sh == {8'h3B, 24'h123456}, "R8 R1 command", 64'(cmd_sh), 64'h3B123456);

        // R7 done persists
        repeat (12) @(negedge clk);
        chk(done && spi_cs_n && !spi_sclk, "R7 done held", 64'({done, spi_cs_n, spi_sclk}), 64'b110);

        // R2 SCLK shape, R9 start while busy
        prep(24'h020000, 32'd8);
        pulse_start(cur_base);
        while (spi_sclk) @(negedge clk);
        while (!spi_sclk) @(negedge clk);
        hi_w = 0;
        while (spi_sclk) begin hi_w++; @(negedge clk); end
        per = hi_w;
        while (!spi_sclk) begin per++; @(negedge clk); end
        chk(hi_w == 2, "R2 sclk high width", 64'(hi_w), 64'd2);
        chk(per == 4, "R2 sclk period", 64'(per), 64'd4);
        pulse_start(24'h0F0F00);
        flash_base = 24'h0;
        wait_done();
        check_load("R9 busy start ignored");

        report_end();
    end
endmodule